// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs the state changes a small 32-bit CPU makes when it enters an exception or accepts an interrupt. A synchronous exception arrives as a request strobe with a type index; an external interrupt arrives as a pending level. The block picks which one is taken and classifies it as a normal or a debug exception. It then produces, in one clock edge, the new program counter, a write of the faulting program counter into either the exception-address or the breakpoint-address register, and the updated interrupt-enable bits.

Normal exceptions save the program counter into the exception-address register and move the global enable into the exception shadow bit. Debug exceptions save it into the breakpoint-address register and move the enable into the breakpoint shadow bit. Debug exceptions always vector through the debug base. Normal exceptions vector through the debug base only while the remap control bit is set, and through the normal base otherwise. The vector is the base plus the type index times 32.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output register clears to zero (`ack`, `err`, `irq_taken`, `ea_we`, `ba_we`, `pc_out`, `save_pc`, `ie_out`). A request presented during reset is not taken.
- R2: Type indices: 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call. A taken exception of type 2, 4, 5, 6 or 7 pulses `ea_we` with `save_pc` equal to `pc_in` and leaves `ba_we` low.
- R3: Enable bits are `ie_in`/`ie_out` bit 0 global enable, bit 1 exception shadow, bit 2 breakpoint shadow. For a normal exception, bit 1 becomes bit1 OR bit0 of the input, bit 0 becomes 0 and bit 2 is unchanged.
- R4: For a normal exception, `pc_out` is `deba + 32*type` when `remap_en` is 1 and `eba + 32*type` when it is 0.
- R5: A taken exception of type 1 or 3 pulses `ba_we` with `save_pc` equal to `pc_in` and leaves `ea_we` low. Bit 2 becomes bit2 OR bit0 of the input, bit 0 becomes 0 and bit 1 is unchanged.
- R6: For a debug exception, `pc_out` is `deba + 32*type` whatever the value of `remap_en`.
- R7: With no synchronous request, a pending interrupt is taken as type 6 and `irq_taken` is pulsed, but only when `ie_in` bit 0 is 1. Otherwise no output pulses.
- R8: A synchronous request with type 0 or with any type of 8 or more pulses `err` for one cycle. `ack`, `ea_we` and `ba_we` stay low.
- R9: The outputs of a request sampled at a rising edge appear right after that edge, for one cycle. `ack` goes high with exactly one of `ea_we`/`ba_we`, and `ack` and `err` are never high together.
- R10: When a synchronous request and a takeable interrupt arrive in the same cycle, the synchronous exception is taken, `irq_taken` stays low, and the interrupt stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request strobe |
| exc_type | input | TYPE_W (4) | Type index of the synchronous exception |
| irq_pending | input | 1 | External interrupt pending level |
| pc_in | input | XLEN (32) | Current program counter |
| eba | input | XLEN (32) | Normal exception base address |
| deba | input | XLEN (32) | Debug exception base address |
| remap_en | input | 1 | Route normal exceptions through the debug base |
| ie_in | input | 3 | Current interrupt-enable register |
| ack | output | 1 | Exception taken (one-cycle pulse) |
| err | output | 1 | Unrecognised type index (one-cycle pulse) |
| irq_taken | output | 1 | The taken exception was the external interrupt |
| pc_out | output | XLEN (32) | New program counter, valid with `ack` |
| ea_we | output | 1 | Write `save_pc` to the exception-address register |
| ba_we | output | 1 | Write `save_pc` to the breakpoint-address register |
| save_pc | output | XLEN (32) | Program counter value to be saved |
| ie_out | output | 3 | Updated interrupt-enable register, valid with `ack` |

## Verification
A synchronous exception and an external interrupt can both claim the same edge. The bench provokes this by asserting `exc_req` together with `irq_pending` while the global enable is 1, for both a normal and a debug type. The result is judged correct when the vector, the saved register and the shadow bit all belong to the synchronous type and `irq_taken` stays low. A following cycle with the interrupt still pending then shows that it is taken as type 6.

// File: rtl/exc_entry_pkg.sv
// Package: shared constants and types for the exception entry controller.
// Assumes type indices are small unsigned integers.
package exc_entry_pkg;

    // Type index encoding
    localparam int unsigned EXC_RESET  = 0;
    localparam int unsigned EXC_BREAK  = 1;
    localparam int unsigned EXC_IBUS   = 2;
    localparam int unsigned EXC_WATCH  = 3;
    localparam int unsigned EXC_DBUS   = 4;
    localparam int unsigned EXC_DIV0   = 5;
    localparam int unsigned EXC_IRQ    = 6;
    localparam int unsigned EXC_SCALL  = 7;

    // Interrupt-enable register bit positions
    localparam int unsigned IEB_GLOBAL = 0;
    localparam int unsigned IEB_EXC    = 1;
    localparam int unsigned IEB_BRK    = 2;
    localparam int unsigned IE_W       = 3;

    // Classification of a candidate exception
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_NORMAL = 2'd1,
        CLS_DEBUG  = 2'd2,
        CLS_BAD    = 2'd3
    } exc_class_e;

endpackage

// File: rtl/exc_arbiter.sv
// Arbiter: chooses between a synchronous exception and an external interrupt.
// Assumes the interrupt is a level that the source holds until it is served.
// A synchronous request always wins; the interrupt needs the global enable.
module exc_arbiter #(
    parameter int unsigned TYPE_W = 4
) (
    input  logic              sync_req,
    input  logic [TYPE_W-1:0] sync_type,
    input  logic              irq_pending,
    input  logic              glob_en,
    output logic              go,
    output logic              from_irq,
    output logic [TYPE_W-1:0] eff_type
);
    import exc_entry_pkg::*;

    localparam logic [TYPE_W-1:0] IRQ_IDX = TYPE_W'(EXC_IRQ);

    logic irq_ok;

    // Decide whether anything is taken this cycle, and which source
    always_comb begin
        irq_ok   = irq_pending && glob_en;
        go       = sync_req || irq_ok;
        from_irq = !sync_req && irq_ok;
        eff_type = sync_req ? sync_type : IRQ_IDX;
    end
endmodule

// File: rtl/exc_classify.sv
// Classifier: maps a type index to normal, debug or unrecognised.
// Assumes the caller gates the result with its own "go" indication.
module exc_classify #(
    parameter int unsigned TYPE_W = 4
) (
    input  logic                       go,
    input  logic [TYPE_W-1:0]          type_idx,
    output exc_entry_pkg::exc_class_e  cls
);
    import exc_entry_pkg::*;

    // Decode the type index into an exception class
    always_comb begin
        if (!go) begin
            cls = CLS_NONE;
        end else begin
            case (int'(type_idx))
                EXC_BREAK, EXC_WATCH:                        cls = CLS_DEBUG;
                EXC_IBUS, EXC_DBUS, EXC_DIV0, EXC_IRQ,
                EXC_SCALL:                                   cls = CLS_NORMAL;
                default:                                     cls = CLS_BAD;
            endcase
        end
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Vector generator: base selection plus scaled type index.
// Debug exceptions always use the debug base; normal ones use it only
// when remapping is enabled. The offset is type << VEC_SHIFT.
module exc_vector_gen #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned TYPE_W    = 4,
    parameter int unsigned VEC_SHIFT = 5
) (
    input  exc_entry_pkg::exc_class_e cls,
    input  logic [TYPE_W-1:0]         type_idx,
    input  logic [XLEN-1:0]           norm_base,
    input  logic [XLEN-1:0]           dbg_base,
    input  logic                      remap,
    output logic [XLEN-1:0]           target
);
    import exc_entry_pkg::*;

    localparam int unsigned PAD_W = XLEN - TYPE_W;

    logic [XLEN-1:0] offset;
    logic            use_dbg;

    // Select the base and add the scaled offset
    always_comb begin
        offset  = {{PAD_W{1'b0}}, type_idx} << VEC_SHIFT;
        use_dbg = (cls == CLS_DEBUG) || remap;
        target  = (use_dbg ? dbg_base : norm_base) + offset;
    end
endmodule

// File: rtl/exc_ie_update.sv
// Enable updater: stashes the global enable into the shadow bit chosen
// by the exception class, then clears the global enable. Other classes
// pass the register through unchanged.
module exc_ie_update (
    input  exc_entry_pkg::exc_class_e       cls,
    input  logic [exc_entry_pkg::IE_W-1:0]  ie_cur,
    output logic [exc_entry_pkg::IE_W-1:0]  ie_next
);
    import exc_entry_pkg::*;

    // Compute the enable register after entry
    always_comb begin
        ie_next = ie_cur;
        case (cls)
            CLS_NORMAL: begin
                ie_next[IEB_EXC]    = ie_cur[IEB_EXC] | ie_cur[IEB_GLOBAL];
                ie_next[IEB_GLOBAL] = 1'b0;
            end
            CLS_DEBUG: begin
                ie_next[IEB_BRK]    = ie_cur[IEB_BRK] | ie_cur[IEB_GLOBAL];
                ie_next[IEB_GLOBAL] = 1'b0;
            end
            default: ie_next = ie_cur;
        endcase
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller (top). Registers every entry side effect on
// the edge that samples the request, so all outputs appear together for
// one cycle. Assumes the consumer writes pc_out, save_pc and ie_out into
// its own state when ack (and ea_we / ba_we) are high.
module exc_entry_ctrl #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned TYPE_W    = 4,
    parameter int unsigned VEC_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [TYPE_W-1:0] exc_type,
    input  logic              irq_pending,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   eba,
    input  logic [XLEN-1:0]   deba,
    input  logic              remap_en,
    input  logic [2:0]        ie_in,
    output logic              ack,
    output logic              err,
    output logic              irq_taken,
    output logic [XLEN-1:0]   pc_out,
    output logic              ea_we,
    output logic              ba_we,
    output logic [XLEN-1:0]   save_pc,
    output logic [2:0]        ie_out
);
    import exc_entry_pkg::*;

    logic              go;
    logic              from_irq;
    logic [TYPE_W-1:0] eff_type;
    exc_class_e        cls;
    logic [XLEN-1:0]   target;
    logic [IE_W-1:0]   ie_next;
    logic              take;

    exc_arbiter #(.TYPE_W(TYPE_W)) u_arb (
        .sync_req    (exc_req),
        .sync_type   (exc_type),
        .irq_pending (irq_pending),
        .glob_en     (ie_in[IEB_GLOBAL]),
        .go          (go),
        .from_irq    (from_irq),
        .eff_type    (eff_type)
    );

    exc_classify #(.TYPE_W(TYPE_W)) u_cls (
        .go       (go),
        .type_idx (eff_type),
        .cls      (cls)
    );

    exc_vector_gen #(
        .XLEN      (XLEN),
        .TYPE_W    (TYPE_W),
        .VEC_SHIFT (VEC_SHIFT)
    ) u_vec (
        .cls       (cls),
        .type_idx  (eff_type),
        .norm_base (eba),
        .dbg_base  (deba),
        .remap     (remap_en),
        .target    (target)
    );

    exc_ie_update u_ie (
        .cls     (cls),
        .ie_cur  (ie_in),
        .ie_next (ie_next)
    );

    // A recognised class means the exception is actually entered
    always_comb take = (cls == CLS_NORMAL) || (cls == CLS_DEBUG);

    // Strobes: single-cycle pulses for the edge that sampled the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            err       <= 1'b0;
            irq_taken <= 1'b0;
            ea_we     <= 1'b0;
            ba_we     <= 1'b0;
        end else begin
            ack       <= take;
            err       <= (cls == CLS_BAD);
            irq_taken <= take && from_irq;
            ea_we     <= (cls == CLS_NORMAL);
            ba_we     <= (cls == CLS_DEBUG);
        end
    end

    // Data: capture vector, saved PC and enables only on a taken entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out  <= '0;
            save_pc <= '0;
            ie_out  <= '0;
        end else if (take) begin
            pc_out  <= target;
            save_pc <= pc_in;
            ie_out  <= ie_next;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Checker: temporal properties of the exception entry controller,
// attached to every instance of the top module by the bind below.
module exc_entry_ctrl_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic            irq_pending,
    input logic [2:0]      ie_in,
    input logic [XLEN-1:0] pc_in,
    input logic            ack,
    input logic            err,
    input logic            irq_taken,
    input logic            ea_we,
    input logic            ba_we,
    input logic [XLEN-1:0] save_pc,
    input logic [2:0]      ie_out
);

    // R9
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && err));

    // R9
    ack_one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ea_we ^ ba_we));

    // R2
    save_matches_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_we || ba_we) |-> (save_pc == $past(pc_in)));

    // R3
    global_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !ie_out[0]);

    // R7
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_req && !(irq_pending && ie_in[0])) |=> (!ack && !err && !irq_taken));

    // R10
    sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> !irq_taken);

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_req     (exc_req),
    .irq_pending (irq_pending),
    .ie_in       (ie_in),
    .pc_in       (pc_in),
    .ack         (ack),
    .err         (err),
    .irq_taken   (irq_taken),
    .ea_we       (ea_we),
    .ba_we       (ba_we),
    .save_pc     (save_pc),
    .ie_out      (ie_out)
);

// File: tb/exc_entry_ctrl_test.sv
// Scoreboard bench: the driver pushes one expected result per cycle,
// the monitor pops and compares it after the sampling edge.
module exc_entry_ctrl_test;

    localparam int XLEN   = 32;
    localparam int TYPE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              exc_req = 1'b0;
    logic [TYPE_W-1:0] exc_type = '0;
    logic              irq_pending = 1'b0;
    logic [XLEN-1:0]   pc_in = '0;
    logic [XLEN-1:0]   eba = '0;
    logic [XLEN-1:0]   deba = '0;
    logic              remap_en = 1'b0;
    logic [2:0]        ie_in = '0;
    logic              ack, err, irq_taken, ea_we, ba_we;
    logic [XLEN-1:0]   pc_out, save_pc;
    logic [2:0]        ie_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct packed {
        logic            ack;
        logic            err;
        logic            irq;
        logic            ea;
        logic            ba;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] save;
        logic [2:0]      ie;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    exc_entry_ctrl #(.XLEN(XLEN), .TYPE_W(TYPE_W)) uut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .irq_pending(irq_pending), .pc_in(pc_in), .eba(eba), .deba(deba),
        .remap_en(remap_en), .ie_in(ie_in), .ack(ack), .err(err),
        .irq_taken(irq_taken), .pc_out(pc_out), .ea_we(ea_we), .ba_we(ba_we),
        .save_pc(save_pc), .ie_out(ie_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result
    task automatic stim(input logic req, input int typ, input logic irq,
                        input logic [XLEN-1:0] pc, input logic [XLEN-1:0] nb,
                        input logic [XLEN-1:0] db, input logic rm,
                        input logic [2:0] ie, input string tag);
        exp_t e;
        int   t;
        bit   dbg, nrm;
        @(negedge clk);
        exc_req = req; exc_type = TYPE_W'(typ); irq_pending = irq;
        pc_in = pc; eba = nb; deba = db; remap_en = rm; ie_in = ie;
        e = '0;
        t = req ? typ : 6;
        if (req || (irq && ie[0])) begin
            dbg = (t == 1 || t == 3);
            nrm = (t == 2 || t == 4 || t == 5 || t == 6 || t == 7);
            if (dbg || nrm) begin
                e.ack  = 1'b1;
                e.irq  = !req;
                e.ea   = nrm;
                e.ba   = dbg;
                e.save = pc;
                e.pc   = ((dbg || rm) ? db : nb) + XLEN'(t * 32);
                e.ie   = dbg ? {ie[2] | ie[0], ie[1], 1'b0}
                             : {ie[2], ie[1] | ie[0], 1'b0};
            end else begin
                e.err = 1'b1;
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            stim(1'b0, 0, 1'b0, '0, '0, '0, 1'b0, 3'b000, "R9 idle");
    endtask

    // Monitor: compare results just after the edge that produced them
    always @(posedge clk) begin
        #5;
        if (rst_n && exp_q.size() > 0) begin
            exp_t  e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, "ack", XLEN'(ack), XLEN'(e.ack));
            check(tg, "err", XLEN'(err), XLEN'(e.err));
            check(tg, "irq_taken", XLEN'(irq_taken), XLEN'(e.irq));
            check(tg, "ea_we", XLEN'(ea_we), XLEN'(e.ea));
            check(tg, "ba_we", XLEN'(ba_we), XLEN'(e.ba));
            if (e.ack) begin
                check(tg, "pc_out", pc_out, e.pc);
                check(tg, "save_pc", save_pc, e.save);
                check(tg, "ie_out", XLEN'(ie_out), XLEN'(e.ie));
            end
        end
    end

    initial begin
        // R1: reset state, with a request held during reset
        exc_req = 1'b1; exc_type = 4'd2; ie_in = 3'b001; pc_in = 32'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "ack", XLEN'(ack), 0);
        check("R1", "err", XLEN'(err), 0);
        check("R1", "ea_we", XLEN'(ea_we), 0);
        check("R1", "ba_we", XLEN'(ba_we), 0);
        check("R1", "pc_out", pc_out, 0);
        check("R1", "save_pc", save_pc, 0);
        check("R1", "ie_out", XLEN'(ie_out), 0);
        exc_req = 1'b0;
        rst_n = 1'b1;

        idle(2);
        // R2 R3 R4: normal exceptions, no remap, enable set
        stim(1, 2, 0, 32'h0000_1000, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R2 R4 ibus");
        stim(1, 4, 0, 32'h0000_1004, 32'h0001_0000, 32'h0002_0000, 0, 3'b101, "R2 R3 dbus");
        stim(1, 5, 0, 32'h0000_2000, 32'h0001_0000, 32'h0002_0000, 0, 3'b000, "R3 div0 ie0");
        stim(1, 7, 0, 32'hDEAD_BEE0, 32'hFFFF_FF00, 32'h0002_0000, 0, 3'b011, "R2 R3 scall");
        // R4: remap routes normal exceptions through the debug base
        stim(1, 7, 0, 32'h0000_3000, 32'h0001_0000, 32'h0002_0000, 1, 3'b001, "R4 remap");
        stim(1, 6, 0, 32'h0000_3004, 32'h0001_0000, 32'h0003_0000, 1, 3'b000, "R4 R2 sync irq type");
        // R5 R6: debug exceptions ignore remap
        stim(1, 1, 0, 32'h0000_4000, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R5 R6 break");
        stim(1, 3, 0, 32'h0000_4004, 32'h0001_0000, 32'h0002_0000, 1, 3'b011, "R5 R6 watch");
        stim(1, 3, 0, 32'h0000_4008, 32'h0001_0000, 32'h0005_0000, 0, 3'b100, "R5 watch ie0");
        idle(1);
        // R7: interrupt gated by the global enable
        stim(0, 0, 1, 32'h0000_5000, 32'h0001_0000, 32'h0002_0000, 0, 3'b000, "R7 irq blocked");
        stim(0, 0, 1, 32'h0000_5004, 32'h0001_0000, 32'h0002_0000, 0, 3'b110, "R7 irq blocked shadows");
        stim(0, 0, 1, 32'h0000_5008, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R7 irq taken");
        stim(0, 0, 1, 32'h0000_500C, 32'h0001_0000, 32'h0002_0000, 1, 3'b101, "R7 R4 irq remap");
        // R10: synchronous exception beats a takeable interrupt
        stim(1, 5, 1, 32'h0000_6000, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R10 div0 vs irq");
        stim(1, 1, 1, 32'h0000_6004, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R10 break vs irq");
        stim(0, 0, 1, 32'h0000_6008, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R10 irq after");
        // R8: unrecognised indices
        stim(1, 0, 0, 32'h0000_7000, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R8 type0");
        stim(1, 9, 0, 32'h0000_7004, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R8 type9");
        stim(1, 15, 1, 32'h0000_7008, 32'h0001_0000, 32'h0002_0000, 1, 3'b001, "R8 R10 type15 with irq");
        stim(1, 8, 0, 32'h0000_700C, 32'h0001_0000, 32'h0002_0000, 0, 3'b000, "R8 type8");
        // R9: back-to-back entries then quiet
        stim(1, 2, 0, 32'h0000_8000, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R9 b2b a");
        stim(1, 4, 0, 32'h0000_8004, 32'h0001_0000, 32'h0002_0000, 0, 3'b001, "R9 b2b b");
        idle(3);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule